// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block predicts the next fetch address from the fetch address alone, before the instruction has been decoded. It keeps a direct-mapped table of taken control transfers. Each slot holds a valid flag, the complete word address of the branch or jump it describes, and the address it last went to. A lookup selects one slot with low bits of the fetch PC and compares the stored address with the whole fetch PC. If they are equal, the stored target is the predicted next PC. Any other outcome gives PC+4. Because the whole address is compared, an ordinary instruction that shares a slot with a branch still falls through to PC+4.

The table is written only after resolution in the execute stage, through a plain update port. A resolved taken branch or jump installs or overwrites its slot. A resolved not-taken branch that owns a valid slot clears that slot. Instructions that do not transfer control leave the table alone. For every resolved control transfer, the block compares the actual next PC with the next PC that was used at fetch time. On a difference it raises a redirect pulse in the same cycle, carrying the correct address, so that the pipeline can kill the wrongly fetched instruction.

Lookups use a valid/ready stream. A request is accepted when `lk_valid` and `lk_ready` are both high. Its prediction appears on the response stream one cycle later. `lk_ready` is high whenever the response register is empty or is being drained in the same cycle. While `pr_valid` is high and `pr_ready` is low, the response and all its fields are held unchanged and no new request is accepted.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every slot is invalid, `pr_valid` is 0 and `lk_ready` is 1, so every lookup made before the first update predicts PC+4 with `pr_hit` 0.
- R2: The slot index is PC bits [8:2] (128 slots). A lookup whose PC differs from the stored address in any of bits [31:2] misses and predicts PC+4, including a PC that maps to an occupied slot.
- R3: A lookup whose PC bits [31:2] equal those of a valid slot returns `pr_hit` 1 and that slot's stored target as `pr_next`.
- R4: An update with `upd_en`, `upd_cti` and `upd_taken` all 1 writes the slot at the index of `upd_pc`, marks it valid and replaces its address and target. The result is visible to lookups accepted in any later cycle.
- R5: An update with `upd_en` 1, `upd_cti` 1 and `upd_taken` 0 invalidates the slot only if that slot is valid and holds `upd_pc`. Otherwise the slot is unchanged.
- R6: An update with `upd_cti` 0 changes no slot and raises no redirect.
- R7: When a lookup is accepted in the same cycle as an update to the same slot, the lookup sees the slot contents from before that update.
- R8: `fix_valid` is 1 in the same cycle as an update with `upd_en` and `upd_cti` 1 whose actual next PC differs from `upd_pred_next`. The actual next PC is `upd_target` if `upd_taken` is 1, otherwise `upd_pc`+4. `fix_pc` then equals the actual next PC.
- R9: A request is accepted when `lk_valid` and `lk_ready` are both 1, and `lk_ready` = !`pr_valid` || `pr_ready`. Each accepted request yields exactly one response, in order, in the next cycle. The response stays stable while `pr_valid` is 1 and `pr_ready` is 0.
- R10: The PC+4 fall-through wraps modulo 2^32, so PC 0xFFFFFFFC predicts 0x00000000 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_pc | input | 32 | Fetch PC to look up |
| pr_valid | output | 1 | Prediction response valid |
| pr_ready | input | 1 | Consumer takes the response |
| pr_pc | output | 32 | Fetch PC the response belongs to |
| pr_next | output | 32 | Predicted next fetch PC |
| pr_hit | output | 1 | The table supplied the prediction |
| upd_en | input | 1 | A resolved instruction is reported |
| upd_cti | input | 1 | The reported instruction is a branch or jump |
| upd_taken | input | 1 | The control transfer was taken |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_target | input | 32 | Resolved target address |
| upd_pred_next | input | 32 | Next PC used when it was fetched |
| fix_valid | output | 1 | Fetch went the wrong way and must be redirected |
| fix_pc | output | 32 | Correct next PC for the redirect |

## Verification
The hardest case to reach from the ports is a lookup and an update that hit the same slot in the same cycle, where the update also changes the outcome. For example, a fill can turn a miss into a hit, or a drop can turn a hit into a miss. With random addresses this almost never happens. The stimulus therefore draws every PC from a small pool in which pairs of addresses share a slot index, and it adds directed cycles that fill and drop the very slot being looked up. Random back-pressure on `pr_ready` causes stalls while the table changes underneath a held response.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Action the resolve logic asks of one table slot
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_FILL = 2'd1,
    ACT_DROP = 2'd2
  } slot_act_e;

  // Sequential step between instruction words, in bytes
  function automatic int unsigned word_step(input int unsigned align_bits);
    return 32'd1 << align_bits;
  endfunction

endpackage

// File: rtl/btb_entry_array.sv
module btb_entry_array
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned ALIGN_W = 2,
  localparam int unsigned SLOTS  = 1 << IDX_W,
  localparam int unsigned TAG_W  = PC_W - ALIGN_W
) (
  input  logic             clk,
  input  logic             rst,
  // fetch-side read port
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [PC_W-1:0]  rd_target,
  // resolve-side probe port
  input  logic [IDX_W-1:0] pb_idx,
  output logic             pb_valid,
  output logic [TAG_W-1:0] pb_tag,
  // write port
  input  slot_act_e        wr_act,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_target
);

  logic [SLOTS-1:0] valid_vec;
  logic [TAG_W-1:0] tag_arr [SLOTS];
  logic [PC_W-1:0]  tgt_arr [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic             here;
    logic             v_q;
    logic [TAG_W-1:0] a_q;
    logic [PC_W-1:0]  t_q;

    assign here = (wr_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (here && wr_act == ACT_FILL) begin
        v_q <= 1'b1;
      end else if (here && wr_act == ACT_DROP) begin
        v_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (here && wr_act == ACT_FILL) begin
        a_q <= wr_tag;
        t_q <= wr_target;
      end
    end

    assign valid_vec[s] = v_q;
    assign tag_arr[s]   = a_q;
    assign tgt_arr[s]   = t_q;
  end

  // reads see the contents before this cycle's write
  assign rd_valid  = valid_vec[rd_idx];
  assign rd_tag    = tag_arr[rd_idx];
  assign rd_target = tgt_arr[rd_idx];

  assign pb_valid  = valid_vec[pb_idx];
  assign pb_tag    = tag_arr[pb_idx];

endmodule

// File: rtl/btb_hit_logic.sv
module btb_hit_logic
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ALIGN_W = 2,
  localparam int unsigned TAG_W  = PC_W - ALIGN_W
) (
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  logic [PC_W-1:0]  slot_target,
  output logic             hit,
  output logic [PC_W-1:0]  next_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(word_step(ALIGN_W));

  logic [PC_W-1:0] seq_pc;

  assign seq_pc  = fetch_pc + STEP;
  assign hit     = slot_valid && (slot_tag == fetch_pc[PC_W-1:ALIGN_W]);
  assign next_pc = hit ? slot_target : seq_pc;

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ALIGN_W = 2,
  localparam int unsigned TAG_W  = PC_W - ALIGN_W
) (
  input  logic             upd_en,
  input  logic             upd_cti,
  input  logic             upd_taken,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [PC_W-1:0]  upd_target,
  input  logic [PC_W-1:0]  upd_pred_next,
  input  logic             pb_valid,
  input  logic [TAG_W-1:0] pb_tag,
  output slot_act_e        wr_act,
  output logic             fix_valid,
  output logic [PC_W-1:0]  fix_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(word_step(ALIGN_W));

  logic            resolved_cti;
  logic            owns_slot;
  logic [PC_W-1:0] actual_next;

  assign resolved_cti = upd_en && upd_cti;
  assign owns_slot    = pb_valid && (pb_tag == upd_pc[PC_W-1:ALIGN_W]);
  assign actual_next  = upd_taken ? upd_target : (upd_pc + STEP);

  always_comb begin
    wr_act = ACT_NONE;
    if (resolved_cti) begin
      if (upd_taken) begin
        wr_act = ACT_FILL;
      end else if (owns_slot) begin
        wr_act = ACT_DROP;
      end
    end
  end

  assign fix_valid = resolved_cti && (actual_next != upd_pred_next);
  assign fix_pc    = actual_next;

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned ALIGN_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  output logic            lk_ready,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pr_valid,
  input  logic            pr_ready,
  output logic [PC_W-1:0] pr_pc,
  output logic [PC_W-1:0] pr_next,
  output logic            pr_hit,
  input  logic            upd_en,
  input  logic            upd_cti,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic [PC_W-1:0] upd_pred_next,
  output logic            fix_valid,
  output logic [PC_W-1:0] fix_pc
);

  localparam int unsigned TAG_W  = PC_W - ALIGN_W;
  localparam int unsigned IDX_LO = ALIGN_W;
  localparam int unsigned IDX_HI = ALIGN_W + IDX_W - 1;

  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  logic [PC_W-1:0]  rd_target;
  logic             pb_valid;
  logic [TAG_W-1:0] pb_tag;
  slot_act_e        wr_act;
  logic             lk_hit;
  logic [PC_W-1:0]  lk_next;
  logic             lk_fire;

  btb_entry_array #(
    .PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)
  ) u_array (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (lk_pc[IDX_HI:IDX_LO]),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_target (rd_target),
    .pb_idx    (upd_pc[IDX_HI:IDX_LO]),
    .pb_valid  (pb_valid),
    .pb_tag    (pb_tag),
    .wr_act    (wr_act),
    .wr_idx    (upd_pc[IDX_HI:IDX_LO]),
    .wr_tag    (upd_pc[PC_W-1:ALIGN_W]),
    .wr_target (upd_target)
  );

  btb_hit_logic #(
    .PC_W(PC_W), .ALIGN_W(ALIGN_W)
  ) u_hit (
    .fetch_pc    (lk_pc),
    .slot_valid  (rd_valid),
    .slot_tag    (rd_tag),
    .slot_target (rd_target),
    .hit         (lk_hit),
    .next_pc     (lk_next)
  );

  btb_resolve #(
    .PC_W(PC_W), .ALIGN_W(ALIGN_W)
  ) u_resolve (
    .upd_en        (upd_en),
    .upd_cti       (upd_cti),
    .upd_taken     (upd_taken),
    .upd_pc        (upd_pc),
    .upd_target    (upd_target),
    .upd_pred_next (upd_pred_next),
    .pb_valid      (pb_valid),
    .pb_tag        (pb_tag),
    .wr_act        (wr_act),
    .fix_valid     (fix_valid),
    .fix_pc        (fix_pc)
  );

  // response register of the lookup stream
  assign lk_ready = !pr_valid || pr_ready;
  assign lk_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid <= 1'b0;
    end else if (lk_fire) begin
      pr_valid <= 1'b1;
    end else if (pr_ready) begin
      pr_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_pc   <= '0;
      pr_next <= '0;
      pr_hit  <= 1'b0;
    end else if (lk_fire) begin
      pr_pc   <= lk_pc;
      pr_next <= lk_next;
      pr_hit  <= lk_hit;
    end
  end

endmodule

// File: rtl/branch_target_buffer_chk.sv
module branch_target_buffer_chk #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ALIGN_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic            pr_valid,
  input logic            pr_ready,
  input logic [PC_W-1:0] pr_pc,
  input logic [PC_W-1:0] pr_next,
  input logic            pr_hit,
  input logic            upd_en,
  input logic            upd_cti,
  input logic [PC_W-1:0] upd_pred_next,
  input logic            fix_valid,
  input logic [PC_W-1:0] fix_pc
);

  localparam logic [PC_W-1:0] STEP = PC_W'(1 << ALIGN_W);

  // R9
  held_resp_chk: assert property (@(posedge clk) disable iff (rst)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_pc) && $stable(pr_next) && $stable(pr_hit));

  // R9
  accept_resp_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid && lk_ready |=> pr_valid);

  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (rst)
    pr_valid && !pr_hit |-> pr_next == pr_pc + STEP);

  // R6
  no_fix_plain_chk: assert property (@(posedge clk) disable iff (rst)
    fix_valid |-> upd_en && upd_cti);

  // R8
  fix_differs_chk: assert property (@(posedge clk) disable iff (rst)
    fix_valid |-> fix_pc != upd_pred_next);

endmodule

bind branch_target_buffer branch_target_buffer_chk #(
  .PC_W(PC_W), .ALIGN_W(ALIGN_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .lk_valid      (lk_valid),
  .lk_ready      (lk_ready),
  .pr_valid      (pr_valid),
  .pr_ready      (pr_ready),
  .pr_pc         (pr_pc),
  .pr_next       (pr_next),
  .pr_hit        (pr_hit),
  .upd_en        (upd_en),
  .upd_cti       (upd_cti),
  .upd_pred_next (upd_pred_next),
  .fix_valid     (fix_valid),
  .fix_pc        (fix_pc)
);

// File: tb/branch_target_buffer_tb.sv
`timescale 1ns/1ps
module branch_target_buffer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_ready;
  logic [31:0] lk_pc = '0;
  logic        pr_valid, pr_ready = 1'b1;
  logic [31:0] pr_pc, pr_next;
  logic        pr_hit;
  logic        upd_en = 1'b0, upd_cti = 1'b0, upd_taken = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0, upd_pred_next = '0;
  logic        fix_valid;
  logic [31:0] fix_pc;

  always #2 clk = ~clk;

  branch_target_buffer u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference table
  bit          m_v   [128];
  logic [29:0] m_tag [128];
  logic [31:0] m_tgt [128];
  bit          e_valid = 1'b0;
  logic [31:0] e_pc = '0, e_next = '0;
  bit          e_hit = 1'b0;
  string       e_note = "R1";

  logic [31:0] pool [8] = '{32'h0000_1000, 32'h0000_1200, 32'h0000_1004, 32'h0000_3004,
                            32'h2000_0010, 32'h4000_0010, 32'hFFFF_FFFC, 32'h0000_01FC};

  function automatic int idx_of(logic [31:0] pc);
    return int'(pc[8:2]);
  endfunction

  function automatic bit ref_hit(logic [31:0] pc);
    return m_v[idx_of(pc)] && (m_tag[idx_of(pc)] == pc[31:2]);
  endfunction

  function automatic logic [31:0] ref_next(logic [31:0] pc);
    return ref_hit(pc) ? m_tgt[idx_of(pc)] : pc + 32'd4;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check, advance the model across the edge
  task automatic cyc(bit lv, logic [31:0] lpc, bit rdy, bit ue, bit uc, bit ut,
                     logic [31:0] upc, logic [31:0] utg, logic [31:0] upn, string note);
    bit          acc, ex_fix;
    logic [31:0] act_next;
    lk_valid = lv; lk_pc = lpc; pr_ready = rdy;
    upd_en = ue; upd_cti = uc; upd_taken = ut; upd_pc = upc; upd_target = utg; upd_pred_next = upn;
    #1;
    check(lk_ready == (!e_valid || rdy), "R9 lk_ready", 32'(lk_ready), 32'(!e_valid || rdy));
    check(pr_valid == e_valid, "R9 pr_valid", 32'(pr_valid), 32'(e_valid));
    if (e_valid) begin
      check(pr_pc == e_pc, {e_note, " pr_pc"}, pr_pc, e_pc);
      check(pr_next == e_next, {e_note, " pr_next"}, pr_next, e_next);
      check(pr_hit == e_hit, {e_note, " pr_hit"}, 32'(pr_hit), 32'(e_hit));
    end
    act_next = ut ? utg : upc + 32'd4;
    ex_fix = ue && uc && (act_next != upn);
    check(fix_valid == ex_fix, uc ? "R8 fix_valid" : "R6 fix_valid", 32'(fix_valid), 32'(ex_fix));
    if (ex_fix) check(fix_pc == act_next, "R8 fix_pc", fix_pc, act_next);
    acc = lv && (!e_valid || rdy);
    if (acc) begin
      e_valid = 1'b1; e_pc = lpc; e_next = ref_next(lpc); e_hit = ref_hit(lpc);
      e_note = (note != "") ? note : (e_hit ? "R3" : "R2");
    end else if (rdy) begin
      e_valid = 1'b0;
    end
    if (ue && uc) begin
      if (ut) begin
        m_v[idx_of(upc)] = 1'b1; m_tag[idx_of(upc)] = upc[31:2]; m_tgt[idx_of(upc)] = utg;
      end else if (ref_hit(upc)) begin
        m_v[idx_of(upc)] = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  task automatic look(logic [31:0] pc, string note);
    cyc(1'b1, pc, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, note);
  endtask

  task automatic upd(bit cti, bit tk, logic [31:0] pc, logic [31:0] tg, string note);
    cyc(1'b0, '0, 1'b1, 1'b1, cti, tk, pc, tg, pc + 32'd4, note);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset
    #1;
    check(pr_valid == 1'b0, "R1 pr_valid", 32'(pr_valid), 0);
    check(lk_ready == 1'b1, "R1 lk_ready", 32'(lk_ready), 1);
    @(negedge clk);
    look(32'h0000_1000, "R1");
    look(32'hFFFF_FFFC, "R10");
    // R4: install then hit
    upd(1'b1, 1'b1, 32'h0000_1000, 32'h0000_8000, "R4");
    look(32'h0000_1000, "R4");
    // R2: alias with same index misses
    look(32'h0000_1200, "R2");
    // R6: plain instruction resolving at the aliased address changes nothing
    upd(1'b0, 1'b1, 32'h0000_1200, 32'h0000_9999, "R6");
    look(32'h0000_1000, "R6");
    look(32'h0000_1200, "R6");
    // R5: not-taken alias does not drop, owner does
    upd(1'b1, 1'b0, 32'h0000_1200, '0, "R5");
    look(32'h0000_1000, "R5");
    upd(1'b1, 1'b0, 32'h0000_1000, '0, "R5");
    look(32'h0000_1000, "R5");
    // R7: fill and lookup of the same slot in one cycle
    cyc(1'b1, 32'h0000_1004, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_1004, 32'h0000_4444, 32'h0000_1008, "R7");
    look(32'h0000_1004, "R4");
    cyc(1'b1, 32'h0000_1004, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_1004, '0, 32'h0000_4444, "R7");
    look(32'h0000_1004, "R5");
    // R8: correct prediction gives no redirect
    cyc(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_3004, 32'h0000_0100, 32'h0000_0100, "R8");
    // R9: stall holds response
    cyc(1'b1, 32'h0000_3004, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, "R9");
    cyc(1'b1, 32'h2000_0010, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0, '0, "");
    cyc(1'b1, 32'h2000_0010, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, "");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] lp, up, tg;
      bit ue, uc, ut;
      lp = pool[$urandom_range(7)];
      up = pool[$urandom_range(7)];
      tg = ($urandom_range(3) == 0) ? pool[$urandom_range(7)] : {$urandom(), 2'b00} ;
      ue = ($urandom_range(2) != 0);
      uc = ($urandom_range(4) != 0);
      ut = $urandom_range(1) == 1;
      cyc($urandom_range(3) != 0, lp, $urandom_range(3) != 0, ue, uc, ut, up, tg,
          ($urandom_range(1) == 1) ? tg : up + 32'd4, "");
    end
    cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, '0, "");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule